// File: doc/BRIEF.md
# Touch-Key Menu Navigation Controller

This block drives a touch-screen panel that shows a horizontal three-item menu. After reset it streams a fixed start-up script to a byte-wide serial transmitter. The script selects a font, turns the cursor off and clears the screen. It then defines four framed touch keys labelled A to D and draws the menu with the items ADD, ORT and TEST, with the first item highlighted.

Once the script is out, the block listens to key codes that a byte receiver delivers. Key A sends a short command that moves the highlight forward. Key C sends one that moves it backward. Each of these moves fires only once. Key B arms both moves again. Every other code is dropped.

A key that arrives while a move is still going out waits in a one-entry holding register. It is acted on once that move completes. Bit-level serialization and reception sit outside the block.

Top module: `menu_nav_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `tx_valid` is 1 and `tx_data` is 0x1B. Both navigation moves start out armed.
- R2: The script opens with 12 bytes. The font command is 0x1B 0x46 FONT_SEL 0x02 0x01, with FONT_SEL defaulting to 0x05. The cursor-off command is 0x1B 0x51 0x43 0x00. The screen-clear command is 0x1B 0x44 0x4C.
- R3: Four key definitions follow, for k = 0 to 3, each 9 bytes long: 0x1B 0x54 0x48, then 1+3k, then 0x0C+3k, then the return code 0x41+k, then 0x02, then the label 0x41+k, then 0x00.
- R4: The script ends with the menu command, 19 bytes long: 0x1B 0x4E 0x48, MENU_X (default 0x60), MENU_Y (default 0x30), 0x01, "ADD", 0x7C, "ORT", 0x7C, "TEST", 0x00. The whole script is 67 bytes.
- R5: After the last script byte is accepted, `tx_valid` stays 0 until a key triggers a move.
- R6: Key code 0x41 sends 0x1B 0x4E 0x4E if the forward move is armed, and then disarms it. If the move is not armed, nothing is sent.
- R7: Key code 0x43 sends 0x1B 0x4E 0x50 if the backward move is armed, and then disarms it. If the move is not armed, nothing is sent.
- R8: Key code 0x42 arms both moves again and sends nothing.
- R9: A byte is transferred on a clock edge where `tx_valid` and `tx_ready` are both 1. While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` holds its value.
- R10: Key codes that arrive before the whole script has been accepted are ignored. They cause no transmission and leave both moves armed.
- R11: A key that arrives while a move is being sent is held and acted on after that move. A further key that arrives while the holding register is full is dropped.
- R12: Key code 0x44 and every code other than 0x41, 0x42 and 0x43 cause no transmission and do not change the arming of either move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_valid | input | 1 | A received key code is present for one cycle |
| rx_data | input | 8 | Received key code |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_data | output | 8 | Offered byte |

## Verification
The bench builds the block with its default parameters: FONT_SEL 0x05, MENU_X 0x60 and MENU_Y 0x30. At this size the full 67-byte script fits in a short run, so every script byte is compared against a list the bench assembles from the requirements. It then sweeps all 256 key codes to confirm that only the three navigation codes have any effect. Stalling `tx_ready` during a move exercises the holding register: a second key is queued, and a third key that arrives while the register is full is dropped.

// File: rtl/menu_nav_pkg.sv
package menu_nav_pkg;
  localparam int BYTE_W      = 8;
  localparam int HDR_LEN     = 12;
  localparam int KEY_CNT     = 4;
  localparam int KEY_DEF_LEN = 9;
  localparam int MENU_LEN    = 19;
  localparam int KEY_BASE    = HDR_LEN;
  localparam int MENU_BASE   = HDR_LEN + KEY_CNT * KEY_DEF_LEN;
  localparam int SCRIPT_LEN  = MENU_BASE + MENU_LEN;
  localparam int NAV_LEN     = 3;
  localparam int IDX_W       = $clog2(SCRIPT_LEN);

  localparam logic [BYTE_W-1:0] ESC_B      = 8'h1B;
  localparam logic [BYTE_W-1:0] KEY_FWD    = 8'h41;
  localparam logic [BYTE_W-1:0] KEY_ARM    = 8'h42;
  localparam logic [BYTE_W-1:0] KEY_BACK   = 8'h43;
  localparam logic [BYTE_W-1:0] NAV_OP     = 8'h4E;
  localparam logic [BYTE_W-1:0] NAV_FWD_OP = 8'h4E;
  localparam logic [BYTE_W-1:0] NAV_BCK_OP = 8'h50;

  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_NAV} seq_state_t;
endpackage

// File: rtl/menu_script_rom.sv
module menu_script_rom
  import menu_nav_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FONT_SEL = 8'h05,
  parameter logic [BYTE_W-1:0] MENU_X   = 8'h60,
  parameter logic [BYTE_W-1:0] MENU_Y   = 8'h30
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] byte_o
);
  logic [KEY_CNT-1:0] key_hit;
  logic [BYTE_W-1:0]  key_byte [KEY_CNT];
  logic [BYTE_W-1:0]  hdr_byte;
  logic [BYTE_W-1:0]  menu_byte;
  logic [4:0]         menu_rel;

  // one decoder per touch key; fields follow from the key index
  for (genvar k = 0; k < KEY_CNT; k++) begin : g_key
    localparam int BASE = KEY_BASE + k * KEY_DEF_LEN;
    logic [3:0] rel;
    assign rel        = 4'(idx - IDX_W'(BASE));
    assign key_hit[k] = (idx >= IDX_W'(BASE)) && (idx < IDX_W'(BASE + KEY_DEF_LEN));
    always_comb begin
      case (rel)
        4'd0:    key_byte[k] = ESC_B;
        4'd1:    key_byte[k] = 8'h54;
        4'd2:    key_byte[k] = 8'h48;
        4'd3:    key_byte[k] = 8'(1 + 3 * k);
        4'd4:    key_byte[k] = 8'(12 + 3 * k);
        4'd5:    key_byte[k] = 8'(65 + k);
        4'd6:    key_byte[k] = 8'h02;
        4'd7:    key_byte[k] = 8'(65 + k);
        default: key_byte[k] = 8'h00;
      endcase
    end
  end

  always_comb begin
    case (idx[3:0])
      4'd0:    hdr_byte = ESC_B;
      4'd1:    hdr_byte = 8'h46;
      4'd2:    hdr_byte = FONT_SEL;
      4'd3:    hdr_byte = 8'h02;
      4'd4:    hdr_byte = 8'h01;
      4'd5:    hdr_byte = ESC_B;
      4'd6:    hdr_byte = 8'h51;
      4'd7:    hdr_byte = 8'h43;
      4'd8:    hdr_byte = 8'h00;
      4'd9:    hdr_byte = ESC_B;
      4'd10:   hdr_byte = 8'h44;
      default: hdr_byte = 8'h4C;
    endcase
  end

  assign menu_rel = 5'(idx - IDX_W'(MENU_BASE));

  always_comb begin
    case (menu_rel)
      5'd0:    menu_byte = ESC_B;
      5'd1:    menu_byte = 8'h4E;
      5'd2:    menu_byte = 8'h48;
      5'd3:    menu_byte = MENU_X;
      5'd4:    menu_byte = MENU_Y;
      5'd5:    menu_byte = 8'h01;
      5'd6:    menu_byte = "A";
      5'd7:    menu_byte = "D";
      5'd8:    menu_byte = "D";
      5'd9:    menu_byte = 8'h7C;
      5'd10:   menu_byte = "O";
      5'd11:   menu_byte = "R";
      5'd12:   menu_byte = "T";
      5'd13:   menu_byte = 8'h7C;
      5'd14:   menu_byte = "T";
      5'd15:   menu_byte = "E";
      5'd16:   menu_byte = "S";
      5'd17:   menu_byte = "T";
      default: menu_byte = 8'h00;
    endcase
  end

  always_comb begin
    byte_o = 8'h00;
    if (idx < IDX_W'(HDR_LEN)) begin
      byte_o = hdr_byte;
    end else if (idx >= IDX_W'(MENU_BASE)) begin
      byte_o = menu_byte;
    end else begin
      for (int k = 0; k < KEY_CNT; k++) begin
        if (key_hit[k]) byte_o = key_byte[k];
      end
    end
  end
endmodule

// File: rtl/menu_key_hold.sv
module menu_key_hold
  import menu_nav_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              accept_en,
  input  logic              take,
  output logic              pend_vld,
  output logic              fire_fwd,
  output logic              fire_back
);
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] code_q, code_d;
  logic              fwd_arm_q, fwd_arm_d;
  logic              bck_arm_q, bck_arm_d;
  logic              load, rearm, hold_en, arm_en;

  assign load  = rx_valid && accept_en && (!vld_q || take);
  assign rearm = take && (code_q == KEY_ARM);

  always_comb begin
    fire_fwd  = take && (code_q == KEY_FWD)  && fwd_arm_q;
    fire_back = take && (code_q == KEY_BACK) && bck_arm_q;
    vld_d     = load ? 1'b1 : (take ? 1'b0 : vld_q);
    code_d    = load ? rx_data : code_q;
    fwd_arm_d = rearm ? 1'b1 : (fire_fwd  ? 1'b0 : fwd_arm_q);
    bck_arm_d = rearm ? 1'b1 : (fire_back ? 1'b0 : bck_arm_q);
    hold_en   = load || take;
    arm_en    = rearm || fire_fwd || fire_back;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= '0;
    end else if (hold_en) begin
      vld_q  <= vld_d;
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_arm_q <= 1'b1;
      bck_arm_q <= 1'b1;
    end else if (arm_en) begin
      fwd_arm_q <= fwd_arm_d;
      bck_arm_q <= bck_arm_d;
    end
  end

  assign pend_vld = vld_q;

  assert_fwd_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_fwd |=> !fwd_arm_q) else $error("forward move still armed");
  assert_back_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_back |=> !bck_arm_q) else $error("backward move still armed");
  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && code_q == KEY_ARM) |=> (fwd_arm_q && bck_arm_q)) else $error("rearm lost");
  assert_early_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_en && !vld_q) |=> !vld_q) else $error("key latched during script");
  assert_hold_keeps_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !take) |=> (vld_q && $stable(code_q))) else $error("held key overwritten");
endmodule

// File: rtl/menu_tx_seq.sv
module menu_tx_seq
  import menu_nav_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_ready,
  input  logic             pend_vld,
  input  logic             fire_fwd,
  input  logic             fire_back,
  output logic             tx_valid,
  output logic             init_done,
  output logic             pend_take,
  output logic             nav_active,
  output logic             nav_back,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] SCRIPT_LAST = IDX_W'(SCRIPT_LEN - 1);
  localparam logic [IDX_W-1:0] NAV_LAST    = IDX_W'(NAV_LEN - 1);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             back_q, back_d;
  logic             step_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    back_d  = back_q;
    case (state_q)
      ST_INIT: begin
        if (tx_ready) begin
          if (idx_q == SCRIPT_LAST) begin
            state_d = ST_IDLE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (fire_fwd || fire_back) begin
          state_d = ST_NAV;
          idx_d   = '0;
          back_d  = fire_back;
        end
      end
      default: begin
        if (tx_ready) begin
          if (idx_q == NAV_LAST) begin
            state_d = ST_IDLE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
    endcase
    step_en = (state_d != state_q) || (idx_d != idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      idx_q   <= '0;
      back_q  <= 1'b0;
    end else if (step_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      back_q  <= back_d;
    end
  end

  assign tx_valid   = (state_q != ST_IDLE);
  assign init_done  = (state_q != ST_INIT);
  assign pend_take  = (state_q == ST_IDLE) && pend_vld;
  assign nav_active = (state_q == ST_NAV);
  assign nav_back   = back_q;
  assign idx        = idx_q;

  assert_script_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT && idx_q == SCRIPT_LAST && tx_ready) |=> !tx_valid)
    else $error("script did not end quietly");
  assert_nav_three_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NAV && idx_q == NAV_LAST && tx_ready) |=> (state_q == ST_IDLE))
    else $error("move length wrong");
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(idx_q)) else $error("advanced without handshake");
endmodule

// File: rtl/menu_nav_ctrl.sv
module menu_nav_ctrl
  import menu_nav_pkg::*;
#(
  parameter logic [7:0] FONT_SEL = 8'h05,
  parameter logic [7:0] MENU_X   = 8'h60,
  parameter logic [7:0] MENU_Y   = 8'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  logic             init_done, pend_take, pend_vld;
  logic             fire_fwd, fire_back, nav_active, nav_back;
  logic [IDX_W-1:0] idx;
  logic [7:0]       script_byte, nav_byte;

  menu_key_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .accept_en (init_done),
    .take      (pend_take),
    .pend_vld  (pend_vld),
    .fire_fwd  (fire_fwd),
    .fire_back (fire_back)
  );

  menu_tx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_ready   (tx_ready),
    .pend_vld   (pend_vld),
    .fire_fwd   (fire_fwd),
    .fire_back  (fire_back),
    .tx_valid   (tx_valid),
    .init_done  (init_done),
    .pend_take  (pend_take),
    .nav_active (nav_active),
    .nav_back   (nav_back),
    .idx        (idx)
  );

  menu_script_rom #(
    .FONT_SEL (FONT_SEL),
    .MENU_X   (MENU_X),
    .MENU_Y   (MENU_Y)
  ) u_rom (
    .idx    (idx),
    .byte_o (script_byte)
  );

  always_comb begin
    case (idx[1:0])
      2'd0:    nav_byte = ESC_B;
      2'd1:    nav_byte = NAV_OP;
      default: nav_byte = nav_back ? NAV_BCK_OP : NAV_FWD_OP;
    endcase
  end

  assign tx_data = nav_active ? nav_byte : (init_done ? 8'h00 : script_byte);

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
    else $error("offered byte changed under stall");
endmodule

// File: tb/tb_menu_nav_ctrl.sv
module tb_menu_nav_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_ready = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;

  int rdy_mode = 2;
  int checks = 0;
  int errors = 0;
  int cap_n = 0;
  logic [7:0] cap [0:511];
  logic [7:0] exp_s [0:127];
  int exp_n = 0;

  menu_nav_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0) tx_ready = 1'b1;
    else if (rdy_mode == 1) tx_ready = ~tx_ready;
    else tx_ready = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      cap[cap_n] = tx_data;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    exp_s[exp_n] = b;
    exp_n++;
  endtask

  task automatic push_str(input string s);
    for (int i = 0; i < s.len(); i++) push(s[i]);
  endtask

  task automatic send_key(input logic [7:0] c);
    @(posedge clk); #2;
    rx_valid = 1'b1; rx_data = c;
    @(posedge clk); #2;
    rx_valid = 1'b0;
  endtask

  // press a key, wait, compare the bytes produced
  task automatic press(input logic [7:0] c, input int n, input logic [7:0] last, input string tag);
    int base;
    base = cap_n;
    send_key(c);
    repeat (12) @(negedge clk);
    chk(tag, cap_n - base, n);
    if (n == 3 && cap_n - base == 3) begin
      chk({tag, " byte0"}, cap[base], 8'h1B);
      chk({tag, " byte1"}, cap[base+1], 8'h4E);
      chk({tag, " byte2"}, cap[base+2], last);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cap_n, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // expected script built from R2, R3 and R4
    push(8'h1B); push(8'h46); push(8'h05); push(8'h02); push(8'h01);
    push(8'h1B); push(8'h51); push(8'h43); push(8'h00);
    push(8'h1B); push(8'h44); push(8'h4C);
    for (int k = 0; k < 4; k++) begin
      push(8'h1B); push(8'h54); push(8'h48);
      push(8'(1 + 3*k)); push(8'(12 + 3*k)); push(8'(65 + k));
      push(8'h02); push(8'(65 + k)); push(8'h00);
    end
    push(8'h1B); push(8'h4E); push(8'h48); push(8'h60); push(8'h30); push(8'h01);
    push_str("ADD"); push(8'h7C); push_str("ORT"); push(8'h7C); push_str("TEST"); push(8'h00);
    chk("R4 script length", exp_n, 67);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", tx_valid, 1);
    chk("R1 first byte in reset", tx_data, 8'h1B);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", tx_valid, 1);
    rdy_mode = 1;

    // R10: forward key and rearm key during the script
    repeat (20) @(posedge clk);
    send_key(8'h41);
    send_key(8'h42);
    while (cap_n < 67) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R5 R10 no bytes past script", cap_n, 67);
    chk("R5 idle valid low", tx_valid, 0);
    for (int i = 0; i < 67; i++) begin
      string t;
      t = (i < 12) ? "R2 header byte" : ((i < 48) ? "R3 key byte" : "R4 menu byte");
      chk($sformatf("%s %0d", t, i), cap[i], exp_s[i]);
    end

    rdy_mode = 0;
    press(8'h41, 3, 8'h4E, "R6 R10 forward first");
    press(8'h41, 0, 8'h00, "R6 forward second");
    press(8'h43, 3, 8'h50, "R7 backward first");
    press(8'h43, 0, 8'h00, "R7 backward second");
    press(8'h42, 0, 8'h00, "R8 rearm silent");
    press(8'h41, 3, 8'h4E, "R8 forward after rearm");
    press(8'h43, 3, 8'h50, "R8 backward after rearm");

    // R12: every other code, with both moves disarmed
    for (int c = 0; c < 256; c++) begin
      if (c != 8'h41 && c != 8'h42 && c != 8'h43)
        press(8'(c), 0, 8'h00, $sformatf("R12 code %0h", c));
    end
    press(8'h41, 0, 8'h00, "R12 forward still disarmed");
    press(8'h43, 0, 8'h00, "R12 backward still disarmed");
    press(8'h42, 0, 8'h00, "R8 rearm again");

    // R9 and R11: stall during a move, queue one key, drop the next
    begin
      int base;
      logic [7:0] seen;
      rdy_mode = 2;
      repeat (2) @(posedge clk);
      base = cap_n;
      send_key(8'h41);
      repeat (3) @(negedge clk);
      chk("R9 valid under stall", tx_valid, 1);
      seen = tx_data;
      chk("R9 first move byte", seen, 8'h1B);
      send_key(8'h43);
      send_key(8'h42);
      repeat (5) @(negedge clk);
      chk("R9 byte held", tx_data, seen);
      chk("R9 nothing taken", cap_n - base, 0);
      rdy_mode = 1;
      repeat (40) @(negedge clk);
      chk("R11 six bytes", cap_n - base, 6);
      chk("R11 byte2", cap[base+2], 8'h4E);
      chk("R11 queued byte0", cap[base+3], 8'h1B);
      chk("R11 queued byte1", cap[base+4], 8'h4E);
      chk("R11 queued byte2", cap[base+5], 8'h50);
      rdy_mode = 0;
    end
    press(8'h41, 0, 8'h00, "R11 dropped rearm");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule